// File: doc/BRIEF.md
# Descriptor ring packet walker

This block is the per-channel engine of a packet mover. It walks a circular ring of 64-bit buffer descriptors held in a small descriptor memory. Each descriptor is a control word and then a buffer address. The engine reads the descriptor at its current index and checks the hardware-ownership flag. It then moves the number of bytes the descriptor names, in one of two directions. In transmit, bytes are read from data memory and sent on a byte stream that carries first and last markers. In receive, bytes taken from a byte stream are written into data memory. After the transfer the engine writes the control word back with ownership returned to software and the complete flag set. It then steps to the next ring slot, wrapping at the ring length.

Software fills the ring while the channel is off. It loads the ring base word address and the ring length, then switches the channel on. To queue a buffer, software sets the ownership flag of the next slot. When the engine meets a slot that software still owns, it goes idle and looks again on the next poll tick. After a write-back it goes straight on to the next slot. A received frame longer than one buffer is spread over consecutive descriptors, with start-of-frame and end-of-frame marked in the written-back control words.

Top module: `dring_walker`

## Requirements
- R1: After reset, and on every cycle the channel is off while the engine is idle, the ring index is 0. After reset no descriptor read or write, no done pulse, no stream byte and no receive-ready occurs until the channel is on.
- R2: A descriptor whose control bit 31 is 0 is neither transferred nor written back, and no done pulse is raised for it. The engine reads that slot again only after a later poll tick.
- R3: Descriptor i occupies word base+2i (control) and word base+2i+1 (buffer byte address). The buffer length in bytes is control bits 15:0.
- R4: In transmit, the bytes at buffer address plus offset are sent in increasing address order. The offset is control bits 27:23, 5 bits wide. tx_first is high only with the first byte and only when bit 29 is set. tx_last is high only with the final byte and only when bit 28 is set.
- R5: In receive, the offset is control bits 25:23, 3 bits wide, and bits 27:26 are ignored. Accepted bytes are written to consecutive addresses from buffer address plus offset. No byte is written outside the received range.
- R6: In receive, the written-back bit 29 is 1 only for the first descriptor of a frame. Bit 28 is 1 only for the descriptor that took the byte marked rx_last. Bits 15:0 hold the number of bytes stored. A full buffer without rx_last continues the frame in the next descriptor.
- R7: The written-back control word has bit 31 cleared, bit 30 set and bits 27:16 unchanged. In transmit, bits 29:28 and 15:0 are also unchanged.
- R8: desc_done is a single-cycle pulse, raised exactly once per completed descriptor and in the same cycle as the control-word write-back.
- R9: After each completed descriptor the index increases by one. It wraps from ring length minus 1 to 0.
- R10: A transmit descriptor with length 0 sends no stream byte and is still written back as complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_on | input | 1 | Channel enable |
| cfg_tx | input | 1 | 1 = transmit (memory to stream), 0 = receive |
| cfg_ring_base | input | DADDR_W | Word address of descriptor 0 |
| cfg_ring_len | input | IDX_W+1 | Number of descriptors in the ring |
| poll_tick | input | 1 | Re-check strobe used while idle |
| dsc_rd | output | 1 | Descriptor memory read (data one cycle later) |
| dsc_wr | output | 1 | Descriptor memory write |
| dsc_addr | output | DADDR_W | Descriptor memory word address |
| dsc_wdata | output | 32 | Descriptor write data |
| dsc_rdata | input | 32 | Descriptor read data |
| mem_rd | output | 1 | Data memory byte read (data one cycle later) |
| mem_wr | output | 1 | Data memory byte write |
| mem_addr | output | MADDR_W | Data memory byte address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_rdata | input | 8 | Data memory read byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_first | output | 1 | First byte of a packet |
| tx_last | output | 1 | Last byte of a packet |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Receive byte ends the frame |
| rx_ready | output | 1 | Engine accepts a receive byte this cycle |
| desc_done | output | 1 | Descriptor completed pulse |
| cur_idx | output | IDX_W | Current ring index |

## Verification
The bench goes after these corner cases:
- the largest 5-bit transmit offset;
- a receive offset field whose two upper bits are set, which a design that decoded five bits would turn into a write far past the buffer;
- a ten-byte frame spread over three four-byte buffers, where a wrong start or end marker or a full-length count in the short last descriptor shows up in the write-backs;
- a slot left with ownership cleared across several poll ticks, which a design ignoring the flag would stream and overwrite;
- a zero-length transmit descriptor, which a careless counter would turn into a 65536-byte burst;
- enough descriptors to wrap the index.

The receive ring is reused for a second short frame, so that a byte written past the received length would overwrite data from the first frame.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int OWN_BIT = 31;
  localparam int CMPL_BIT = 30;
  localparam int SOP_BIT = 29;
  localparam int EOP_BIT = 28;
  localparam int OFS_HI = 27;
  localparam int OFS_LO = 23;
  localparam int LEN_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GETC, ST_GETA, ST_EVAL, ST_MOVE, ST_BACK
  } walk_st_e;

  // transmit decodes the full 5-bit field, receive only its low 3 bits
  function automatic logic [4:0] buf_ofs(input logic [4:0] fld, input logic tx);
    buf_ofs = tx ? fld : {2'b00, fld[2:0]};
  endfunction

  // control word handed back to software after a descriptor completes
  function automatic logic [31:0] back_word(input logic [31:0] ctl, input logic tx,
                                            input logic sop, input logic eop,
                                            input logic [LEN_W-1:0] nbytes);
    logic [31:0] w;
    w = ctl;
    w[OWN_BIT] = 1'b0;
    w[CMPL_BIT] = 1'b1;
    if (!tx) begin
      w[SOP_BIT] = sop;
      w[EOP_BIT] = eop;
      w[LEN_W-1:0] = nbytes;
    end
    back_word = w;
  endfunction
endpackage

// File: rtl/dring_ptr.sv
module dring_ptr #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W:0]   ring_len,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] ONE_I = {{(IDX_W-1){1'b0}}, 1'b1};
  localparam logic [IDX_W:0]   ONE_L = {{IDX_W{1'b0}}, 1'b1};

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i, input logic [IDX_W:0] n);
    step = (({1'b0, i} + ONE_L) >= n) ? '0 : i + ONE_I;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (clr) idx <= '0;
    else if (adv) idx <= step(idx, ring_len);
  end

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (idx == '0) || (idx == $past(idx) + ONE_I));

  // R1
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0));
endmodule

// File: rtl/dring_mover.sv
module dring_mover #(
  parameter int MADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               is_tx,
  input  logic [MADDR_W-1:0] start_addr,
  input  logic [15:0]        nbytes,
  input  logic               sop,
  input  logic               eop,
  output logic               fin,
  output logic [15:0]        moved,
  output logic               saw_last,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_first,
  output logic               tx_last,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  output logic               rx_ready
);
  logic               active, tx_q, sop_q, eop_q, stop_q;
  logic [15:0]        cnt, len_q;
  logic [MADDR_W-1:0] addr_q;
  logic               rdv_q, first_q, last_q;
  logic               room, rd_go, wr_go;

  assign room      = (cnt != len_q);
  assign rd_go     = active & tx_q & room;
  assign rx_ready  = active & ~tx_q & room & ~stop_q;
  assign wr_go     = rx_ready & rx_valid;
  assign fin       = active & (tx_q ? ~room : (~room | stop_q));
  assign mem_rd    = rd_go;
  assign mem_wr    = wr_go;
  assign mem_addr  = addr_q + MADDR_W'(cnt);
  assign mem_wdata = rx_data;
  assign moved     = cnt;
  assign saw_last  = stop_q;
  assign tx_valid  = rdv_q;
  assign tx_first  = first_q;
  assign tx_last   = last_q;
  assign tx_data   = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; tx_q <= 1'b0; sop_q <= 1'b0; eop_q <= 1'b0; stop_q <= 1'b0;
      cnt <= '0; len_q <= '0; addr_q <= '0;
      rdv_q <= 1'b0; first_q <= 1'b0; last_q <= 1'b0;
    end else begin
      rdv_q   <= rd_go;
      first_q <= rd_go & sop_q & (cnt == 16'd0);
      last_q  <= rd_go & eop_q & (cnt == len_q - 16'd1);
      if (start) begin
        active <= 1'b1; tx_q <= is_tx; sop_q <= sop; eop_q <= eop;
        len_q <= nbytes; addr_q <= start_addr; cnt <= '0; stop_q <= 1'b0;
      end else if (fin) begin
        active <= 1'b0;
      end else if (rd_go | wr_go) begin
        cnt <= cnt + 16'd1;
        if (wr_go & rx_last) stop_q <= 1'b1;
      end
    end
  end

  // R4
  tx_first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_first |-> tx_valid);

  // R4
  tx_last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R5
  rx_no_write_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_rd);
endmodule

// File: rtl/dring_walker.sv
module dring_walker
  import dring_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int DADDR_W = 10,
  parameter int MADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_on,
  input  logic               cfg_tx,
  input  logic [DADDR_W-1:0] cfg_ring_base,
  input  logic [IDX_W:0]     cfg_ring_len,
  input  logic               poll_tick,
  output logic               dsc_rd,
  output logic               dsc_wr,
  output logic [DADDR_W-1:0] dsc_addr,
  output logic [31:0]        dsc_wdata,
  input  logic [31:0]        dsc_rdata,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_first,
  output logic               tx_last,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  output logic               rx_ready,
  output logic               desc_done,
  output logic [IDX_W-1:0]   cur_idx
);
  localparam logic [DADDR_W-1:0] ONE_D = {{(DADDR_W-1){1'b0}}, 1'b1};

  walk_st_e           st;
  logic [31:0]        ctl_q;
  logic               frame_open;
  logic [IDX_W-1:0]   idx;
  logic [DADDR_W-1:0] slot_addr;
  logic               ev_take, ev_back, ev_clr;
  logic               mv_fin, mv_last;
  logic [15:0]        mv_moved;
  logic [MADDR_W-1:0] buf_start;

  // named events used by the state machine and the assertions
  assign ev_take   = (st == ST_EVAL) & ctl_q[OWN_BIT];
  assign ev_back   = (st == ST_BACK);
  assign ev_clr    = (st == ST_IDLE) & ~chan_on;
  assign slot_addr = cfg_ring_base + DADDR_W'({idx, 1'b0});
  assign buf_start = dsc_rdata[MADDR_W-1:0] + MADDR_W'(buf_ofs(ctl_q[OFS_HI:OFS_LO], cfg_tx));

  assign dsc_rd    = (st == ST_GETC) | (st == ST_GETA);
  assign dsc_addr  = (st == ST_GETA) ? slot_addr + ONE_D : slot_addr;
  assign dsc_wr    = ev_back;
  assign dsc_wdata = back_word(ctl_q, cfg_tx, frame_open, mv_last, mv_moved);
  assign desc_done = ev_back;
  assign cur_idx   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ctl_q <= '0;
      frame_open <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: if (chan_on & poll_tick) st <= ST_GETC;
        ST_GETC: st <= ST_GETA;
        ST_GETA: begin ctl_q <= dsc_rdata; st <= ST_EVAL; end
        ST_EVAL: st <= ev_take ? ST_MOVE : ST_IDLE;
        ST_MOVE: if (mv_fin) st <= ST_BACK;
        ST_BACK: st <= chan_on ? ST_GETC : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (ev_clr) frame_open <= 1'b1;
      else if (ev_back & ~cfg_tx) frame_open <= mv_last;
    end
  end

  dring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ev_clr), .adv(ev_back),
    .ring_len(cfg_ring_len), .idx(idx)
  );

  dring_mover #(.MADDR_W(MADDR_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(ev_take), .is_tx(cfg_tx),
    .start_addr(buf_start), .nbytes(ctl_q[LEN_W-1:0]),
    .sop(ctl_q[SOP_BIT]), .eop(ctl_q[EOP_BIT]),
    .fin(mv_fin), .moved(mv_moved), .saw_last(mv_last),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);

  // R2
  owned_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MOVE) |-> ctl_q[OWN_BIT]);

  // R7
  wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_wr |-> (!dsc_wdata[OWN_BIT] && dsc_wdata[CMPL_BIT]));

  // R3
  wb_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_wr |-> !dsc_rd && !mem_rd && !mem_wr);
endmodule

// File: tb/test_dring_walker.sv
module test_dring_walker;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int IDX_W = 6, DADDR_W = 10, MADDR_W = 16;
  localparam int DBASE = 8;
  // [15:8] length, [7:3] offset, [1] start flag, [0] end flag
  localparam logic [15:0] TXV [5] = '{16'h0303, 16'h05FA, 16'h0238, 16'h0409, 16'h0103};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, chan_on, cfg_tx, poll_tick;
  logic [DADDR_W-1:0] cfg_ring_base;
  logic [IDX_W:0] cfg_ring_len;
  logic dsc_rd, dsc_wr, mem_rd, mem_wr;
  logic [DADDR_W-1:0] dsc_addr;
  logic [31:0] dsc_wdata, dsc_rdata;
  logic [MADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, tx_data, rx_data;
  logic tx_valid, tx_first, tx_last, rx_valid, rx_last, rx_ready, desc_done;
  logic [IDX_W-1:0] cur_idx;

  dring_walker #(.IDX_W(IDX_W), .DADDR_W(DADDR_W), .MADDR_W(MADDR_W)) i_dring_walker (
    .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .cfg_tx(cfg_tx),
    .cfg_ring_base(cfg_ring_base), .cfg_ring_len(cfg_ring_len), .poll_tick(poll_tick),
    .dsc_rd(dsc_rd), .dsc_wr(dsc_wr), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata),
    .dsc_rdata(dsc_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .desc_done(desc_done), .cur_idx(cur_idx)
  );

  logic [31:0] dram [0:255];
  logic [7:0]  dmem [0:1023];

  always @(posedge clk) begin
    if (dsc_rd) dsc_rdata <= dram[dsc_addr[7:0]];
    if (dsc_wr) dram[dsc_addr[7:0]] <= dsc_wdata;
    if (mem_rd) mem_rdata <= dmem[mem_addr[9:0]];
    if (mem_wr) dmem[mem_addr[9:0]] <= mem_wdata;
  end

  int n_done = 0, n_byte = 0, n_chk = 0, n_bad = 0;
  logic [7:0] cap_d [0:511];
  logic cap_f [0:511];
  logic cap_l [0:511];

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (desc_done) n_done++;
      if (tx_valid && n_byte < 512) begin
        cap_d[n_byte] = tx_data; cap_f[n_byte] = tx_first; cap_l[n_byte] = tx_last;
        n_byte++;
      end
    end
  end

  initial begin
    poll_tick = 1'b0;
    forever begin
      repeat (7) @(negedge clk);
      poll_tick = 1'b1;
      @(negedge clk);
      poll_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(input int target);
    int t = 0;
    while (n_done < target && t < 3000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic arm(input int slot, input logic [31:0] ctl, input logic [31:0] adr);
    dram[DBASE + 2*slot + 1] = adr;
    dram[DBASE + 2*slot] = ctl;
  endtask

  task automatic send_frame(input int n, input logic [7:0] b0);
    for (int k = 0; k < n; k++) begin
      int t = 0;
      rx_valid = 1'b1; rx_data = b0 + 8'(k); rx_last = (k == n-1);
      while (!rx_ready && t < 3000) begin @(negedge clk); t++; end
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int a);
    pat = 8'(a * 7 + 3);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ctl, saved;
    int d0, b0, slot;
    for (int i = 0; i < 256; i++) dram[i] = '0;
    for (int i = 0; i < 1024; i++) dmem[i] = pat(i);
    rst_n = 1'b0; chan_on = 1'b0; cfg_tx = 1'b1; rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    cfg_ring_base = DADDR_W'(DBASE); cfg_ring_len = 7'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset index", 32'(cur_idx), 0);
    chk("R1", "reset done", 32'(desc_done), 0);
    chk("R1", "reset stream", 32'(tx_valid), 0);
    chk("R1", "reset rx ready", 32'(rx_ready), 0);
    repeat (10) @(negedge clk);
    chk("R1", "no fetch while off", 32'(dsc_rd | dsc_wr), 0);
    chan_on = 1'b1;

    // transmit vector table
    for (int v = 0; v < 5; v++) begin
      logic [7:0] len; logic [4:0] ofs; logic s, e; int ba;
      len = TXV[v][15:8]; ofs = TXV[v][7:3]; s = TXV[v][1]; e = TXV[v][0];
      slot = v % 4; ba = 128 + 64*v;
      ctl = {1'b1, 1'b0, s, e, ofs, 7'h35, 8'h00, len};
      b0 = n_byte; d0 = n_done;
      arm(slot, ctl, 32'(ba));
      wait_done(d0 + 1);
      chk("R8", "one done per descriptor", 32'(n_done - d0), 1);
      chk("R3", "byte count from length field", 32'(n_byte - b0), 32'(len));
      for (int k = 0; k < int'(len); k++) begin
        chk("R4", "tx byte", 32'(cap_d[b0+k]), 32'(pat(ba + int'(ofs) + k)));
        chk("R4", "tx first", 32'(cap_f[b0+k]), 32'((k == 0) && s));
        chk("R4", "tx last", 32'(cap_l[b0+k]), 32'((k == int'(len) - 1) && e));
      end
      chk("R7", "tx writeback", dram[DBASE + 2*slot], {1'b0, 1'b1, ctl[29:0]});
      chk("R9", "index step", 32'(cur_idx), 32'((slot + 1) % 4));
    end

    // R2 slot 1 is software-owned: stays untouched across poll ticks
    saved = dram[DBASE + 2];
    d0 = n_done; b0 = n_byte;
    repeat (40) @(negedge clk);
    chk("R2", "no done on owned-by-software", 32'(n_done), 32'(d0));
    chk("R2", "slot unchanged", dram[DBASE + 2], saved);
    ctl = {1'b0, 1'b0, 1'b1, 1'b1, 5'd0, 7'h35, 16'd3};
    arm(1, ctl, 32'd700);
    repeat (40) @(negedge clk);
    chk("R2", "fresh unowned slot unchanged", dram[DBASE + 2], ctl);
    chk("R2", "no bytes sent", 32'(n_byte), 32'(b0));
    chk("R2", "index held", 32'(cur_idx), 1);

    // R10 zero-length transmit
    ctl = {1'b1, 1'b0, 1'b1, 1'b1, 5'd4, 7'h35, 16'd0};
    d0 = n_done;
    arm(1, ctl, 32'd700);
    wait_done(d0 + 1);
    chk("R10", "zero-length bytes", 32'(n_byte), 32'(b0));
    chk("R10", "zero-length writeback", dram[DBASE + 2], {1'b0, 1'b1, ctl[29:0]});
    chk("R9", "index after zero-length", 32'(cur_idx), 2);

    // R1 channel off clears index
    chan_on = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "index cleared when off", 32'(cur_idx), 0);

    // receive: ring of 3, buffers of 4 bytes, offset field 5'b11010 -> 2
    cfg_tx = 1'b0; cfg_ring_len = 7'd3;
    ctl = {1'b1, 1'b0, 1'b0, 1'b0, 5'b11010, 7'h35, 16'd4};
    for (int i = 0; i < 3; i++) arm(i, ctl, 32'(512 + 32*i));
    chan_on = 1'b1;
    d0 = n_done;
    send_frame(10, 8'hA0);
    wait_done(d0 + 3);
    chk("R6", "rx first desc", dram[DBASE + 0], {4'b0110, ctl[27:16], 16'd4});
    chk("R6", "rx middle desc", dram[DBASE + 2], {4'b0100, ctl[27:16], 16'd4});
    chk("R6", "rx final desc", dram[DBASE + 4], {4'b0101, ctl[27:16], 16'd2});
    for (int k = 0; k < 10; k++)
      chk("R5", "rx byte", 32'(dmem[512 + 32*(k/4) + 2 + (k%4)]), 32'(8'hA0 + 8'(k)));
    chk("R5", "below offset untouched", 32'(dmem[513]), 32'(pat(513)));
    chk("R5", "past short buffer untouched", 32'(dmem[576 + 4]), 32'(pat(580)));
    chk("R9", "rx index wrapped", 32'(cur_idx), 0);

    d0 = n_done;
    arm(0, ctl, 32'd512);
    send_frame(3, 8'hB0);
    wait_done(d0 + 1);
    chk("R6", "single-buffer frame", dram[DBASE + 0], {4'b0111, ctl[27:16], 16'd3});
    chk("R5", "second frame byte", 32'(dmem[516]), 32'hB2);
    chk("R5", "no write past received length", 32'(dmem[517]), 32'hA3);
    chk("R9", "rx index step", 32'(cur_idx), 1);
    chk("R8", "done count", 32'(n_done - d0), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule